// File: doc/BRIEF.md
# Compare-Channel Interval Timer

This block is a timer peripheral on a plain 32-bit register bus. An up-counter advances once every 2^P clock cycles, where P is a prescaler selection. It runs only while a clock-mode field in the control register selects counting. When the counter reaches a programmable wrap value, it returns to zero and raises a sticky overflow flag.

One compare channel in software-compare mode watches the counter. The channel flag sets when the counter steps onto the programmed compare value. The flag drives the interrupt output when the channel's interrupt enable is set. Software clears the flag by writing a one to the flag bit in the channel control register, or by writing a one to bit 0 of the global status register.

The counter width is a build parameter of 16 or 32 bits, and a read-only information register reports it. The bus and the counter share one clock. Writes take effect at the clock edge that samples them. Read data is registered and is valid on the cycle after the read request.

Top module: `cmp_timer`

## Requirements
- R1: The information register at offset 0x04 reads the counter width in bits 23:16 (0x10 or 0x20) and zero in every other bit. Writes to it have no effect.
- R2: After reset:
  - the control register, the counter, channel control and the compare value are zero;
  - the wrap register holds all ones of the counter width;
  - the interrupt output is low.
- R3: The counter advances only while the clock-mode field, bits 4:3 of the control register at 0x10, equals 01. With any other value it holds.
- R4: With prescaler selection P in bits 2:0 of the control register, the counter has advanced floor(k/2^P) times after k clock edges of counting that start from a stopped state. Any write to the counter register at 0x14 sets the counter to zero and restarts the prescaler phase.
- R5: When the counter advances from the value in the wrap register at 0x18, it goes to zero and sets the overflow flag, bit 7 of the control register.
- R6: A control-register write with bit 7 set clears the overflow flag. A write with bit 7 clear leaves the flag unchanged.
- R7: If the channel mode field, bits 5:2 of channel control at 0x20, equals 4 (software compare), an advance that makes the counter equal the compare value at 0x24 sets the channel flag, bit 7 of channel control. An advance that lands on zero through a wrap also counts.
- R8: The channel flag reads as bit 0 of the global status register at 0x1C. Writing a one to either bit 0 at 0x1C or bit 7 at 0x20 clears it. Writing a zero to those bits leaves it unchanged.
- R9: The interrupt output is high exactly while the channel flag and the channel interrupt enable (bit 6 at 0x20) are both set.
- R10: With the mode field at any value other than 4, no new channel flag is raised. A flag that is already set remains set.
- R11: When a compare match and a clearing write of the channel flag happen in the same cycle, the flag ends up set.
- R12: Writes to the wrap and compare registers keep only the low counter-width bits. Reads of these registers and of the counter are zero-extended to 32 bits. Read data appears on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Channel interrupt |

## Verification
A write lands at the clock edge that samples it. A read returns its data one edge later, so the bench samples bus_rdata at the falling edge that follows the read edge. The counter is started by one control write and stopped by another k edges later, which fixes its final value at floor(k/2^P) advances counted modulo wrap+1. The bench reads the counter only after it has been stopped. A compare match sets the flag at the edge where the counter takes the matching value. The same-cycle priority test therefore places its status write on exactly the fifth edge after the start write. The interrupt is a plain function of registered state and is checked half a cycle after each edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] OFS_INFO  = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam logic [7:0] OFS_COUNT = 8'h14;
  localparam logic [7:0] OFS_WRAP  = 8'h18;
  localparam logic [7:0] OFS_STAT  = 8'h1C;
  localparam logic [7:0] OFS_CHCTL = 8'h20;
  localparam logic [7:0] OFS_CHVAL = 8'h24;

  localparam logic [1:0] CLK_MODE_RUN  = 2'b01;
  localparam logic [3:0] CH_MODE_SWCMP = 4'h4;

  typedef struct packed {
    logic [1:0] cmode;
    logic [2:0] presc;
  } ctrl_t;

  typedef struct packed {
    logic       ie;
    logic [3:0] mode;
  } chcfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;

  always_comb begin
    mask  = ~({DIV_W{1'b1}} << sel);
    tick  = en && ((div_q & mask) == mask);
    div_d = (!en || restart) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);
  p_every_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel == '0) |-> tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] wrap,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt_val,
  output logic             adv,
  output logic             wrap_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_wrap;

  always_comb begin
    at_wrap  = (cnt_q == wrap);
    nxt_val  = at_wrap ? '0 : cnt_q + 1'b1;
    adv      = tick && !clr;
    wrap_evt = adv && at_wrap;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = nxt_val;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt_q == wrap) |=> (cnt_q == '0));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  chcfg_t           cfg_in,
  input  logic             val_we,
  input  logic [CNT_W-1:0] val_in,
  input  logic             clr_req,
  input  logic             adv,
  input  logic [CNT_W-1:0] nxt_val,
  output chcfg_t           cfg,
  output logic [CNT_W-1:0] val,
  output logic             flag,
  output logic             irq
);
  chcfg_t           cfg_q, cfg_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic             flag_q, flag_d, set_evt;

  always_comb begin
    set_evt = adv && (cfg_q.mode == CH_MODE_SWCMP) && (nxt_val == val_q);
    cfg_d   = cfg_we ? cfg_in : cfg_q;
    val_d   = val_we ? val_in : val_q;
    if (set_evt)      flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      val_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      val_q  <= val_d;
      flag_q <= flag_d;
    end
  end

  assign cfg  = cfg_q;
  assign val  = val_q;
  assign flag = flag_q;
  assign irq  = flag_q & cfg_q.ie;

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag_q);
  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);
  p_win_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_req) |=> flag_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int PRE_W = 3;
  localparam logic [7:0] WIDTH_CODE = 8'(CNT_W);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  ctrl_t            ctrl_q, ctrl_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W-1:0] wrap_q, wrap_d;
  logic [31:0]      rdata_q, rdata_d;

  logic we_ctrl, we_count, we_wrap, we_stat, we_chctl, we_chval;
  logic run, tick, adv, wrap_evt, ch_flag, ch_clr;
  logic [CNT_W-1:0] cnt, nxt_val, ch_val;
  chcfg_t           ch_cfg, ch_cfg_in;

  always_comb begin
    we_ctrl  = bus_we && (bus_addr == OFS_CTRL);
    we_count = bus_we && (bus_addr == OFS_COUNT);
    we_wrap  = bus_we && (bus_addr == OFS_WRAP);
    we_stat  = bus_we && (bus_addr == OFS_STAT);
    we_chctl = bus_we && (bus_addr == OFS_CHCTL);
    we_chval = bus_we && (bus_addr == OFS_CHVAL);
    run      = (ctrl_q.cmode == CLK_MODE_RUN);
    ch_clr   = (we_chctl && bus_wdata[7]) || (we_stat && bus_wdata[0]);
    ch_cfg_in.ie   = bus_wdata[6];
    ch_cfg_in.mode = bus_wdata[5:2];
  end

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_ni),
    .en      (run),
    .restart (we_count),
    .sel     (ctrl_q.presc),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ni),
    .tick     (tick),
    .clr      (we_count),
    .wrap     (wrap_q),
    .cnt      (cnt),
    .nxt_val  (nxt_val),
    .adv      (adv),
    .wrap_evt (wrap_evt)
  );

  tmr_channel #(.CNT_W(CNT_W)) u_ch0 (
    .clk     (clk),
    .rst_n   (rst_ni),
    .cfg_we  (we_chctl),
    .cfg_in  (ch_cfg_in),
    .val_we  (we_chval),
    .val_in  (CNT_W'(bus_wdata)),
    .clr_req (ch_clr),
    .adv     (adv),
    .nxt_val (nxt_val),
    .cfg     (ch_cfg),
    .val     (ch_val),
    .flag    (ch_flag),
    .irq     (irq)
  );

  always_comb begin
    ctrl_d = we_ctrl ? ctrl_t'(bus_wdata[4:0]) : ctrl_q;
    wrap_d = we_wrap ? CNT_W'(bus_wdata) : wrap_q;
    if (wrap_evt)                     ovf_d = 1'b1;
    else if (we_ctrl && bus_wdata[7]) ovf_d = 1'b0;
    else                              ovf_d = ovf_q;
    rdata_d = rdata_q;
    if (bus_re) begin
      case (bus_addr)
        OFS_INFO:  rdata_d = {8'h00, WIDTH_CODE, 16'h0000};
        OFS_CTRL:  rdata_d = {24'h0, ovf_q, 2'b00, ctrl_q};
        OFS_COUNT: rdata_d = 32'(cnt);
        OFS_WRAP:  rdata_d = 32'(wrap_q);
        OFS_STAT:  rdata_d = {31'h0, ch_flag};
        OFS_CHCTL: rdata_d = {24'h0, ch_flag, ch_cfg, 2'b00};
        OFS_CHVAL: rdata_d = 32'(ch_val);
        default:   rdata_d = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ovf_q   <= 1'b0;
      wrap_q  <= '1;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      ovf_q   <= ovf_d;
      wrap_q  <= wrap_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  p_info_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_re && bus_addr == OFS_INFO) |=> (bus_rdata == {8'h00, WIDTH_CODE, 16'h0000}));
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    wrap_evt |=> ovf_q);
  p_ovf_keep_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_q && !(we_ctrl && bus_wdata[7])) |=> ovf_q);
  p_ovf_clr_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_ctrl && bus_wdata[7] && !wrap_evt) |=> !ovf_q);
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !ch_cfg.ie |-> !irq);

  generate
    if (CNT_W < 32) begin : g_narrow
      p_zext_r12: assert property (@(posedge clk) disable iff (!rst_ni)
        (bus_re && (bus_addr == OFS_WRAP || bus_addr == OFS_COUNT))
          |=> (bus_rdata[31:CNT_W] == '0));
    end
  endgenerate
endmodule

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  localparam int W = 16;

  logic        clk, rst_n, bus_we, bus_re, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rv;
  int checks = 0;
  int errors = 0;

  cmp_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [15:0] wrap;
    logic [2:0]  presc;
    logic [15:0] cval;
    logic        sw;
    logic [15:0] k;
    logic [15:0] ecnt;
    logic        eovf;
    logic        eflag;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'hFFFF, 3'd0, 16'd10, 1'b1, 16'd10,  16'd10, 1'b0, 1'b1},
    '{16'hFFFF, 3'd0, 16'd11, 1'b1, 16'd10,  16'd10, 1'b0, 1'b0},
    '{16'hFFFF, 3'd3, 16'd4,  1'b1, 16'd35,  16'd4,  1'b0, 1'b1},
    '{16'h0007, 3'd0, 16'd3,  1'b1, 16'd10,  16'd2,  1'b1, 1'b1},
    '{16'h0007, 3'd1, 16'd0,  1'b1, 16'd17,  16'd0,  1'b1, 1'b1},
    '{16'h0005, 3'd2, 16'd6,  1'b1, 16'd30,  16'd1,  1'b1, 1'b0},
    '{16'hFFFF, 3'd7, 16'd1,  1'b1, 16'd300, 16'd2,  1'b0, 1'b1},
    '{16'hFFFF, 3'd0, 16'd3,  1'b0, 16'd10,  16'd10, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_for(input int k);
    wr(8'h10, 32'h0000_0008 | 32'(k >> 16));
  endtask

  task automatic burst(input logic [2:0] p, input int k);
    wr(8'h10, {27'h0, 2'b01, p});
    repeat (k - 1) @(negedge clk);
    wr(8'h10, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    check("R2 irq", {31'h0, irq}, 32'h0);
    rd(8'h10, rv); check("R2 ctrl", rv, 32'h0);
    rd(8'h14, rv); check("R2 count", rv, 32'h0);
    rd(8'h18, rv); check("R2 wrap", rv, 32'h0000_FFFF);
    rd(8'h20, rv); check("R2 chctl", rv, 32'h0);
    rd(8'h24, rv); check("R2 chval", rv, 32'h0);

    // R1 info register, writes ignored
    rd(8'h04, rv); check("R1 info", rv, 32'h0010_0000);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, rv); check("R1 info after write", rv, 32'h0010_0000);

    // R12 masking and zero extension
    wr(8'h18, 32'hABCD_1234);
    rd(8'h18, rv); check("R12 wrap mask", rv, 32'h0000_1234);
    wr(8'h24, 32'h5A5A_8765);
    rd(8'h24, rv); check("R12 chval mask", rv, 32'h0000_8765);

    // Vector table: R4 R5 R7 R10
    foreach (VECS[i]) begin
      wr(8'h10, 32'h80);
      wr(8'h1C, 32'h1);
      wr(8'h18, 32'(VECS[i].wrap));
      wr(8'h24, 32'(VECS[i].cval));
      wr(8'h20, VECS[i].sw ? 32'h50 : 32'h40);
      wr(8'h14, 32'h0);
      burst(VECS[i].presc, int'(VECS[i].k));
      rd(8'h14, rv); check($sformatf("R4 R5 vec%0d count", i), rv, 32'(VECS[i].ecnt));
      rd(8'h10, rv); check($sformatf("R5 vec%0d ovf", i), {31'h0, rv[7]}, {31'h0, VECS[i].eovf});
      rd(8'h1C, rv); check($sformatf("R7 R10 vec%0d flag", i), rv, {31'h0, VECS[i].eflag});
      check($sformatf("R9 vec%0d irq", i), {31'h0, irq}, {31'h0, VECS[i].eflag});
    end

    // R4 counter write clears
    rd(8'h14, rv); check("R4 count nonzero before clear", {31'h0, rv != 0}, 32'h1);
    wr(8'h14, 32'h1234);
    rd(8'h14, rv); check("R4 count cleared", rv, 32'h0);

    // R3 other clock modes hold the counter
    wr(8'h10, 32'h10);
    repeat (10) @(negedge clk);
    wr(8'h10, 32'h18);
    repeat (10) @(negedge clk);
    wr(8'h10, 32'h0);
    rd(8'h14, rv); check("R3 count held", rv, 32'h0);

    // R6 overflow W1C
    wr(8'h1C, 32'h1);
    wr(8'h18, 32'h2);
    wr(8'h14, 32'h0);
    burst(3'd0, 3);
    rd(8'h10, rv); check("R6 ovf set, zero write kept it", rv, 32'h80);
    wr(8'h10, 32'h80);
    rd(8'h10, rv); check("R6 ovf cleared", rv, 32'h0);

    // R11 set wins over same-cycle clear: match lands on edge 5
    wr(8'h18, 32'hFFFF);
    wr(8'h24, 32'd5);
    wr(8'h20, 32'h50);
    wr(8'h1C, 32'h1);
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h08);
    repeat (4) @(negedge clk);
    wr(8'h1C, 32'h1);
    wr(8'h10, 32'h0);
    rd(8'h20, rv); check("R11 flag survives clear", rv, 32'hD0);
    check("R11 irq", {31'h0, irq}, 32'h1);

    // R8 clear via status register
    wr(8'h1C, 32'h1);
    rd(8'h20, rv); check("R8 status clear", rv, 32'h50);
    check("R8 irq low", {31'h0, irq}, 32'h0);

    // R8 clear via channel control, zero write keeps it
    wr(8'h24, 32'd1);
    wr(8'h14, 32'h0);
    burst(3'd0, 1);
    rd(8'h1C, rv); check("R8 status mirrors flag", rv, 32'h1);
    wr(8'h1C, 32'h0);
    wr(8'h20, 32'h50);
    rd(8'h20, rv); check("R8 zero writes keep flag", rv, 32'hD0);
    wr(8'h20, 32'hD0);
    rd(8'h20, rv); check("R8 chctl clear", rv, 32'h50);

    // R10 mode cleared: flag kept, no new flag
    wr(8'h14, 32'h0);
    burst(3'd0, 1);
    wr(8'h20, 32'h40);
    rd(8'h20, rv); check("R10 flag kept", rv, 32'hC0);
    check("R10 irq kept", {31'h0, irq}, 32'h1);
    wr(8'h1C, 32'h1);
    wr(8'h14, 32'h0);
    burst(3'd0, 1);
    rd(8'h20, rv); check("R10 no new flag", rv, 32'h40);

    // R9 enable gating
    wr(8'h20, 32'h10);
    wr(8'h14, 32'h0);
    burst(3'd0, 1);
    rd(8'h20, rv); check("R9 flag without enable", rv, 32'h90);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    wr(8'h20, 32'h50);
    check("R9 irq enabled", {31'h0, irq}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule